// File: doc/BRIEF.md
# Root Hub Port Status and Control Registers

This block holds one 16-bit status and control word for each downstream port of a USB host controller's root hub. Software reads and writes the words through a single indexed access path. Device attach and detach events arrive from the port side and update the connection, speed and change flags. Software uses the block to enable ports, acknowledge change flags and start port resets.

Each write that starts a port reset on a port with a device present produces a one-cycle bus reset request toward that port. A global reset input requests a bus reset on every port that has a device. A controller reset input clears every word and then restores the connection state of each device that is still present. A read of an index past the last implemented port returns a fixed filler value.

Top module: `rh_port_regs`

## Requirements
- R1: On asynchronous reset (rst_ni low) every port word reads 0x0000 and bus_reset_o is all zero.
- R2: A write to an implemented port sets bit 2 (enable), bit 9 (port reset) and bits 15..10 to the written value. Bits 0 and 4 to 8 keep their previous value. The new word is visible on rdata_o in the cycle after the write edge.
- R3: Bits 1 (connect change) and 3 (enable change) keep their value on a write, except that a bit written as 1 is cleared.
- R4: A write that sets bit 9 while it was 0, on a port whose dev_present_i bit is 1, raises that port's bus_reset_o bit for exactly the one cycle after the write edge.
- R5: A write that leaves bit 9 at 1 when it was already 1, or a write to a port with no device present, raises no bus_reset_o bit.
- R6: An attach event sets bit 0 (connected) and bit 1 (connect change). It sets bit 8 when low_speed_i is 1 for that port and clears bit 8 when low_speed_i is 0.
- R7: A detach event on a connected port clears bit 0 and sets bit 1. On an enabled port it also clears bit 2 and sets bit 3. A detach event on a port that is neither connected nor enabled leaves the word unchanged.
- R8: A read with idx_i at or above NUM_PORTS returns 0xFF7F.
- R9: A global reset pulse raises, in the next cycle, the bus_reset_o bit of every port whose dev_present_i bit is 1 and of no other port.
- R10: A controller reset clears every port word. For each port with a device present it then sets bits 0 and 1, and sets bit 8 from low_speed_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hc_reset_i | input | 1 | Synchronous controller reset |
| glb_reset_i | input | 1 | Global bus reset request |
| wr_en_i | input | 1 | Software write strobe |
| idx_i | input | IDX_W | Port index for the read and write path |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data of the indexed port (combinational) |
| attach_i | input | NUM_PORTS | One-cycle attach event for each port |
| detach_i | input | NUM_PORTS | One-cycle detach event for each port |
| low_speed_i | input | NUM_PORTS | Speed of the attaching device for each port |
| dev_present_i | input | NUM_PORTS | A device is present on the port |
| bus_reset_o | output | NUM_PORTS | One-cycle bus reset request for each port |

## Verification
A wrong merge of kept bits and written bits appears on rdata_o in the cycle after the write edge, so each write is followed at once by a read-back of the word. A stale copy of bit 9 shows up as a missing or extra bus_reset_o pulse in that same cycle. A missed detach or a missed controller reset restore shows in the connect and enable fields on the next read. Because the write path keeps bits 0 and 4 to 8, a corrupted kept bit stays visible in every later read until an event or a reset overwrites it.

// File: rtl/rh_port_pkg.sv
package rh_port_pkg;
  localparam int REG_W = 16;
  localparam int CONN_B     = 0;
  localparam int CONN_CHG_B = 1;
  localparam int EN_B       = 2;
  localparam int EN_CHG_B   = 3;
  localparam int LOWSPD_B   = 8;
  localparam int PRST_B     = 9;
  localparam logic [REG_W-1:0] KEEP_MASK  = 16'h01FB;
  localparam logic [REG_W-1:0] W1C_MASK   = 16'h000A;
  localparam logic [REG_W-1:0] ABSENT_VAL = 16'hFF7F;
endpackage

// File: rtl/rh_port_cell.sv
module rh_port_cell
  import rh_port_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hc_reset_i,
  input  logic             glb_reset_i,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             attach_i,
  input  logic             detach_i,
  input  logic             low_speed_i,
  input  logic             present_i,
  output logic [REG_W-1:0] status_o,
  output logic             bus_reset_o
);
  logic [REG_W-1:0] q, d, merged, base;
  logic             rst_req;

  always_comb begin
    merged = (q & KEEP_MASK) | (wdata_i & ~KEEP_MASK);
    merged = merged & ~(wdata_i & W1C_MASK);
    base   = wr_i ? merged : q;
    d      = base;
    if (attach_i) begin
      d[CONN_B]     = 1'b1;
      d[CONN_CHG_B] = 1'b1;
      d[LOWSPD_B]   = low_speed_i;
    end
    if (detach_i) begin
      if (d[CONN_B]) begin
        d[CONN_B]     = 1'b0;
        d[CONN_CHG_B] = 1'b1;
      end
      if (d[EN_B]) begin
        d[EN_B]     = 1'b0;
        d[EN_CHG_B] = 1'b1;
      end
    end
    if (hc_reset_i) begin
      d = '0;
      if (present_i) begin
        d[CONN_B]     = 1'b1;
        d[CONN_CHG_B] = 1'b1;
        d[LOWSPD_B]   = low_speed_i;
      end
    end
  end

  // bus reset only on a rising reset bit or a global reset, and only with a device
  assign rst_req = !hc_reset_i && present_i &&
                   ((wr_i && wdata_i[PRST_B] && !q[PRST_B]) || glb_reset_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q           <= '0;
      bus_reset_o <= 1'b0;
    end else begin
      q           <= d;
      bus_reset_o <= rst_req;
    end
  end

  assign status_o = q;

  // R2
  keep_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !attach_i && !detach_i && !hc_reset_i) |=>
      ((q & KEEP_MASK & ~W1C_MASK) == ($past(q) & KEEP_MASK & ~W1C_MASK)));
  // R3
  w1c_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wdata_i[CONN_CHG_B] && !attach_i && !detach_i && !hc_reset_i) |=> !q[CONN_CHG_B]);
  // R4
  pulse_on_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wdata_i[PRST_B] && !q[PRST_B] && present_i && !hc_reset_i) |=> bus_reset_o);
  // R5
  no_spurious_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !glb_reset_i) |=> !bus_reset_o);
  // R6
  attach_sets_conn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (attach_i && !detach_i && !hc_reset_i) |=> (q[CONN_B] && q[CONN_CHG_B]));
  // R7
  detach_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (detach_i && !hc_reset_i) |=> (!q[CONN_B] && !q[EN_B]));
  // R10
  hc_reset_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hc_reset_i |=> (!q[EN_B] && !q[PRST_B] && !bus_reset_o));
endmodule

// File: rtl/rh_port_rdmux.sv
module rh_port_rdmux
  import rh_port_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int IDX_W     = 4
) (
  input  logic [IDX_W-1:0] idx_i,
  input  logic [REG_W-1:0] words_i [NUM_PORTS],
  output logic [REG_W-1:0] rdata_o
);
  always_comb begin
    rdata_o = ABSENT_VAL;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (idx_i == IDX_W'(p)) rdata_o = words_i[p];
    end
  end
endmodule

// File: rtl/rh_port_regs.sv
module rh_port_regs
  import rh_port_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int IDX_W     = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 hc_reset_i,
  input  logic                 glb_reset_i,
  input  logic                 wr_en_i,
  input  logic [IDX_W-1:0]     idx_i,
  input  logic [REG_W-1:0]     wdata_i,
  output logic [REG_W-1:0]     rdata_o,
  input  logic [NUM_PORTS-1:0] attach_i,
  input  logic [NUM_PORTS-1:0] detach_i,
  input  logic [NUM_PORTS-1:0] low_speed_i,
  input  logic [NUM_PORTS-1:0] dev_present_i,
  output logic [NUM_PORTS-1:0] bus_reset_o
);
  logic [REG_W-1:0] words [NUM_PORTS];

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
    logic wr_sel;
    assign wr_sel = wr_en_i && (idx_i == IDX_W'(g));
    rh_port_cell u_cell (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .hc_reset_i  (hc_reset_i),
      .glb_reset_i (glb_reset_i),
      .wr_i        (wr_sel),
      .wdata_i     (wdata_i),
      .attach_i    (attach_i[g]),
      .detach_i    (detach_i[g]),
      .low_speed_i (low_speed_i[g]),
      .present_i   (dev_present_i[g]),
      .status_o    (words[g]),
      .bus_reset_o (bus_reset_o[g])
    );
  end

  rh_port_rdmux #(.NUM_PORTS(NUM_PORTS), .IDX_W(IDX_W)) u_rdmux (
    .idx_i   (idx_i),
    .words_i (words),
    .rdata_o (rdata_o)
  );

  // R8
  absent_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(idx_i) >= NUM_PORTS) |-> (rdata_o == ABSENT_VAL));
  // R9
  glb_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (glb_reset_i && !hc_reset_i && !wr_en_i) |=> (bus_reset_o == $past(dev_present_i)));
endmodule

// File: tb/rh_port_regs_bench.sv
module rh_port_regs_bench;
  localparam int NP = 2;
  localparam int IW = 4;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          hc_reset_i = 1'b0;
  logic          glb_reset_i = 1'b0;
  logic          wr_en_i = 1'b0;
  logic [IW-1:0] idx_i = '0;
  logic [15:0]   wdata_i = '0;
  logic [15:0]   rdata_o;
  logic [NP-1:0] attach_i = '0;
  logic [NP-1:0] detach_i = '0;
  logic [NP-1:0] low_speed_i = '0;
  logic [NP-1:0] dev_present_i = '0;
  logic [NP-1:0] bus_reset_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rh_port_regs #(.NUM_PORTS(NP), .IDX_W(IW)) u_rh_port_regs (
    .clk_i(clk), .rst_ni(rst_ni), .hc_reset_i(hc_reset_i), .glb_reset_i(glb_reset_i),
    .wr_en_i(wr_en_i), .idx_i(idx_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .attach_i(attach_i), .detach_i(detach_i), .low_speed_i(low_speed_i),
    .dev_present_i(dev_present_i), .bus_reset_o(bus_reset_o)
  );

  // {port[39:36], wdata[35:20], expected word[19:4], pad[3:1], pulse[0]}
  localparam logic [39:0] VEC [8] = '{
    {4'd0, 16'h0004, 16'h0007, 3'b0, 1'b0},  // R2 enable set, kept bits hold
    {4'd0, 16'h000E, 16'h0005, 3'b0, 1'b0},  // R3 clear change bits
    {4'd0, 16'hFC05, 16'hFC05, 3'b0, 1'b0},  // R2 upper bits writable
    {4'd0, 16'h01F0, 16'h0001, 3'b0, 1'b0},  // R2 bits 4..8 kept
    {4'd0, 16'h0204, 16'h0205, 3'b0, 1'b1},  // R4 reset bit rises
    {4'd0, 16'h0204, 16'h0205, 3'b0, 1'b0},  // R5 already set
    {4'd0, 16'h0000, 16'h0001, 3'b0, 1'b0},  // R2 clear reset bit
    {4'd1, 16'h0206, 16'h0204, 3'b0, 1'b0}   // R5 no device
  };

  task automatic check16(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic read_chk(string req, int port, logic [15:0] exp);
    @(negedge clk);
    idx_i = IW'(port);
    #1;
    check16(req, rdata_o, exp);
  endtask

  // write then sample word and pulse in the cycle after the write edge
  task automatic do_write(string req, int port, logic [15:0] data,
                          logic [15:0] exp, logic [NP-1:0] exp_pulse);
    @(negedge clk);
    idx_i = IW'(port); wdata_i = data; wr_en_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0;
    #1;
    check16(req, rdata_o, exp);
    check16(req, 16'(bus_reset_o), 16'(exp_pulse));
  endtask

  task automatic event_pulse(logic [NP-1:0] att, logic [NP-1:0] det);
    @(negedge clk);
    attach_i = att; detach_i = det;
    @(negedge clk);
    attach_i = '0; detach_i = '0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    read_chk("R1", 0, 16'h0000);
    read_chk("R1", 1, 16'h0000);
    check16("R1", 16'(bus_reset_o), 16'h0000);
    rst_ni = 1'b1;
    @(negedge clk);

    // R6 full-speed attach on port 0
    dev_present_i[0] = 1'b1; low_speed_i[0] = 1'b0;
    event_pulse(2'b01, 2'b00);
    read_chk("R6", 0, 16'h0003);

    for (int i = 0; i < 8; i++) begin
      logic [NP-1:0] ep;
      ep = VEC[i][0] ? NP'(1 << VEC[i][39:36]) : '0;
      do_write("R2/R3/R4/R5 vector", int'(VEC[i][39:36]), VEC[i][35:20], VEC[i][19:4], ep);
    end

    // R7 detach of an enabled connected port
    do_write("R2", 0, 16'h0004, 16'h0005, 2'b00);
    dev_present_i[0] = 1'b0;
    event_pulse(2'b00, 2'b01);
    read_chk("R7", 0, 16'h000A);
    event_pulse(2'b00, 2'b01);
    read_chk("R7 idle detach", 0, 16'h000A);
    do_write("R3", 0, 16'h000A, 16'h0000, 2'b00);

    // R6 low-speed attach on port 1, then a full-speed attach clears bit 8
    dev_present_i[1] = 1'b1; low_speed_i[1] = 1'b1;
    event_pulse(2'b10, 2'b00);
    read_chk("R6 low speed", 1, 16'h0307);
    low_speed_i[1] = 1'b0;
    event_pulse(2'b10, 2'b00);
    read_chk("R6 full speed", 1, 16'h0207);
    low_speed_i[1] = 1'b1;

    // R9 global reset
    dev_present_i[0] = 1'b1;
    @(negedge clk); glb_reset_i = 1'b1;
    @(negedge clk); glb_reset_i = 1'b0; #1;
    check16("R9", 16'(bus_reset_o), 16'h0003);
    dev_present_i[0] = 1'b0;
    @(negedge clk); glb_reset_i = 1'b1;
    @(negedge clk); glb_reset_i = 1'b0; #1;
    check16("R9", 16'(bus_reset_o), 16'h0002);
    @(negedge clk); #1;
    check16("R4 single cycle", 16'(bus_reset_o), 16'h0000);

    // R10 controller reset restores present devices only
    @(negedge clk); hc_reset_i = 1'b1;
    @(negedge clk); hc_reset_i = 1'b0;
    read_chk("R10", 0, 16'h0000);
    read_chk("R10", 1, 16'h0103);

    // R8 absent port reads
    read_chk("R8", 2, 16'hFF7F);
    read_chk("R8", 15, 16'hFF7F);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule